// File: doc/BRIEF.md
# Block-Framed Pixel Input Flow Controller

This block sits at the pixel input of a block-based transform compressor while it is encoding. Pixel samples arrive with a valid strobe, in blocks of a fixed length (64 samples by default). A block-sync strobe must come with the final sample of each block. If it does, the next block flows in without a gap. If it does not, the controller finishes and forwards the current block, and then refuses further samples until a sync pulse re-arms it.

The controller also tracks how many of the downstream coefficient buffers are full (four by default). The count rises when a block completes and falls on each release pulse from the consumer. When three buffers are full, the controller raises `stop_o` so that the frame source halts after the block it is already sending. That block still fits in the last free buffer. A sample that arrives with every buffer full is an overflow: the controller sets a sticky status flag and drops to idle. A start pulse opens a new session.

Accepted samples are forwarded one cycle later on the output port. The last sample of each block is marked on that output.

Top module: `pfc_top`

## Requirements
- R1: After reset, `state_o` is 0 (idle), and `stop_o`, `ovf_o` and `out_valid_o` are all 0.
- R2: In idle, a `start_i` pulse moves `state_o` to 1 (running) on the next cycle and clears the overflow flag, the sample position and the buffer occupancy. Outside idle, `start_i` is ignored. In idle, pixel samples are not accepted.
- R3: In running state, every cycle with `pix_valid_i` high accepts the sample. The next cycle shows it on `out_data_o` with `out_valid_o` high. `out_last_o` is high for the 64th sample of each block. A sync strobe on any sample other than the 64th has no effect.
- R4: If the 64th sample arrives without `pix_sync_i`, that sample is still forwarded and `state_o` becomes 2 (waiting). While waiting, no sample is accepted.
- R5: While waiting, a cycle with `pix_sync_i` high returns `state_o` to 1 on the next cycle. The sample offered in that cycle is dropped. The wait has no time limit.
- R6: Buffer occupancy goes up by one for each completed block and down by one for each `buf_release_i` pulse. A release while occupancy is 0 is ignored. A completion and a release in the same cycle cancel out.
- R7: `stop_o` is high exactly while occupancy is 3 or more, and it falls as soon as releases bring occupancy below 3.
- R8: A block that starts while `stop_o` is high is accepted in full and fills the fourth buffer without overflow.
- R9: A sample offered in running state while all four buffers are full sets `ovf_o`. That sample is not forwarded, `state_o` returns to 0, and the sample position restarts at 0.
- R10: `ovf_o` stays high through idle until the next accepted `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Session start pulse (honoured in idle only) |
| pix_valid_i | input | 1 | Pixel sample present |
| pix_data_i | input | DATA_W | Pixel sample |
| pix_sync_i | input | 1 | Block sync, expected with the final sample of a block |
| buf_release_i | input | 1 | Consumer has freed one coefficient buffer |
| stop_o | output | 1 | Source must halt after the current block |
| ovf_o | output | 1 | Sticky overflow flag |
| state_o | output | 2 | 0 idle, 1 running, 2 waiting for sync |
| out_valid_o | output | 1 | Forwarded sample valid |
| out_data_o | output | DATA_W | Forwarded sample |
| out_last_o | output | 1 | Forwarded sample ends a block |

## Verification
Random stimulus drives sparse and bursty valid patterns. Sync is given on most block ends and left out on the rest, and stray syncs fall in the middle of blocks. Release rates are chosen so that occupancy keeps hovering around the stop level. Together these separate a correct block count from one that is off by one, and they show whether a stray sync is wrongly taken. Directed sequences then cover the specific corners:
- Fill three buffers without any release, then finish the fourth block and then offer one more sample. This separates the early stop from a real overflow.
- Hold a long wait with valid high, to show that samples in the waiting state are dropped.
- Release with occupancy at zero, to expose a count that wraps below zero.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } pfc_state_e;
endpackage

// File: rtl/pfc_blk_cnt.sv
module pfc_blk_cnt #(
  parameter int BLK_LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLK_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (inc_i) begin
      if (last_o)          cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && last_o && !clr_i) |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/pfc_occ.sv
module pfc_occ #(
  parameter int NUM_BUF  = 4,
  parameter int STOP_LVL = NUM_BUF - 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o,
  output logic stop_o
);
  localparam int OW = $clog2(NUM_BUF + 1);

  logic [OW-1:0] occ_q;
  logic          dec_ok;

  assign dec_ok = dec_i && (occ_q != '0);
  assign full_o = (occ_q == OW'(NUM_BUF));
  assign stop_o = (occ_q >= OW'(STOP_LVL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      occ_q <= '0;
    else if (clr_i)   occ_q <= '0;
    else begin
      case ({inc_i, dec_ok})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  AST_OCC_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= OW'(NUM_BUF)); // R6
  AST_OCC_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !clr_i) |=> (occ_q == OW'($past(occ_q) + 1'b1))); // R6
  AST_OCC_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == '0 && !inc_i && !clr_i) |=> (occ_q == '0)); // R6
endmodule

// File: rtl/pfc_fsm.sv
module pfc_fsm
  import pfc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       valid_i,
  input  logic       sync_i,
  input  logic       last_i,
  input  logic       full_i,
  output pfc_state_e state_o,
  output logic       acc_o,
  output logic       done_o,
  output logic       abort_o,
  output logic       clr_o,
  output logic       ovf_o
);
  pfc_state_e state_q, state_d;
  logic       ovf_q;
  logic       take;

  assign take    = (state_q == ST_RUN) && valid_i;
  assign abort_o = take && full_i;
  assign acc_o   = take && !full_i;
  assign done_o  = acc_o && last_i;
  assign clr_o   = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN: begin
        if (abort_o)                 state_d = ST_IDLE;
        else if (done_o && !sync_i)  state_d = ST_WAIT;
      end
      ST_WAIT: if (sync_i) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clr_o)        ovf_q <= 1'b0;
      else if (abort_o) ovf_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign ovf_o   = ovf_q;

  AST_MISS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sync_i) |=> (state_q == ST_WAIT)); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> (state_q == ST_IDLE)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_o) |=> ovf_q); // R10
  AST_START_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> (state_q == ST_RUN && !ovf_q)); // R2
endmodule

// File: rtl/pfc_top.sv
module pfc_top
  import pfc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BLK_LEN  = 64,
  parameter int NUM_BUF  = 4,
  parameter int STOP_LVL = NUM_BUF - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  input  logic              pix_sync_i,
  input  logic              buf_release_i,
  output logic              stop_o,
  output logic              ovf_o,
  output logic [1:0]        state_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o
);
  pfc_state_e state;
  logic last, full, acc, done, abort, clr;

  pfc_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_i (pix_valid_i),
    .sync_i  (pix_sync_i),
    .last_i  (last),
    .full_i  (full),
    .state_o (state),
    .acc_o   (acc),
    .done_o  (done),
    .abort_o (abort),
    .clr_o   (clr),
    .ovf_o   (ovf_o)
  );

  pfc_blk_cnt #(.BLK_LEN(BLK_LEN)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr || abort),
    .inc_i  (acc),
    .last_o (last)
  );

  pfc_occ #(.NUM_BUF(NUM_BUF), .STOP_LVL(STOP_LVL)) u_occ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (done),
    .dec_i  (buf_release_i),
    .full_o (full),
    .stop_o (stop_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else begin
      out_valid_o <= acc;
      out_last_o  <= done;
      if (acc) out_data_o <= pix_data_i;
    end
  end

  assign state_o = state;

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT) |=> !out_valid_o); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |=> !out_valid_o); // R2
  AST_NO_OVERFLOW_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> !out_valid_o); // R9
endmodule

// File: tb/sim_pfc_top.sv
module sim_pfc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       st = 1'b0, v = 1'b0, s = 1'b0, r = 1'b0;
  logic [7:0] d = '0;
  logic       stop, ovf, ov, ol;
  logic [1:0] state;
  logic [7:0] od;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pfc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st), .pix_valid_i(v), .pix_data_i(d),
    .pix_sync_i(s), .buf_release_i(r), .stop_o(stop), .ovf_o(ovf), .state_o(state),
    .out_valid_o(ov), .out_data_o(od), .out_last_o(ol)
  );

  // reference model, built from the requirements
  logic [1:0] m_state;
  int         m_cnt, m_occ;
  logic       m_ovf, m_ov, m_ol;
  logic [7:0] m_od;

  function automatic logic exp_stop(int occ);
    return occ >= 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 2'd0; m_cnt <= 0; m_occ <= 0; m_ovf <= 1'b0;
      m_ov <= 1'b0; m_ol <= 1'b0; m_od <= '0;
    end else begin
      int inc;
      inc = 0;
      m_ov <= 1'b0; m_ol <= 1'b0;
      case (m_state)
        2'd0: if (st) begin m_state <= 2'd1; m_cnt <= 0; m_ovf <= 1'b0; end
        2'd1: if (v) begin
          if (m_occ == 4) begin
            m_ovf <= 1'b1; m_state <= 2'd0; m_cnt <= 0;
          end else begin
            m_ov <= 1'b1; m_od <= d; m_ol <= (m_cnt == 63);
            if (m_cnt == 63) begin
              m_cnt <= 0; inc = 1;
              if (!s) m_state <= 2'd2;
            end else m_cnt <= m_cnt + 1;
          end
        end
        default: if (s) m_state <= 2'd1;
      endcase
      if (m_state == 2'd0 && st) m_occ <= 0;
      else m_occ <= m_occ + inc - ((r && m_occ > 0) ? 1 : 0);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R4 state", state, m_state);
    chk("R7 stop", stop, exp_stop(m_occ));
    chk("R9 ovf", ovf, m_ovf);
    chk("R3 out_valid", ov, m_ov);
    if (m_ov) chk("R3 out_data", od, m_od);
    chk("R3 out_last", ol, m_ol);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic idle_in();
    st = 0; v = 0; s = 0; r = 0;
  endtask

  task automatic send_block(bit with_sync);
    for (int i = 0; i < 64; i++) begin
      idle_in(); v = 1; d = 8'(i * 3 + 1); s = with_sync && (i == 63);
      cyc();
    end
    idle_in();
  endtask

  task automatic do_start();
    idle_in(); st = 1; cyc(); idle_in();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 state", state, 0); chk("R1 stop", stop, 0);
    chk("R1 ovf", ovf, 0);     chk("R1 out_valid", ov, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: samples in idle ignored, start moves to running
    idle_in(); v = 1; d = 8'hAA; cyc(); cyc();
    chk("R2 idle no out", ov, 0);
    do_start();
    chk("R2 run", state, 1);

    // R6: release at zero ignored; three blocks then raise stop
    r = 1; cyc(); idle_in();
    send_block(1); send_block(1);
    chk("R7 stop low at 2", stop, 0);
    send_block(1);
    chk("R7 stop at 3", stop, 1);
    chk("R6 zero release ignored", stop, 1);
    // R8: fourth block accepted
    send_block(1);
    chk("R8 no ovf", ovf, 0); chk("R8 running", state, 1);
    // R9: one more sample overflows
    v = 1; d = 8'h55; cyc(); idle_in();
    chk("R9 ovf set", ovf, 1); chk("R9 idle", state, 0); chk("R9 dropped", ov, 0);
    repeat (5) cyc();
    chk("R10 sticky", ovf, 1);
    do_start();
    chk("R10 cleared", ovf, 0); chk("R2 occ cleared", stop, 0);

    // R4/R5: missing sync, long wait with valid high, then resume
    send_block(0);
    chk("R4 wait", state, 2);
    for (int i = 0; i < 200; i++) begin
      v = 1; d = 8'(i); cyc();
      if (ov) chk("R4 no accept in wait", ov, 0);
    end
    s = 1; v = 1; cyc(); idle_in();
    chk("R5 resumed", state, 1); chk("R5 sync sample dropped", ov, 0);
    // R6/R7: releases drop stop, completion+release cancel
    send_block(1); send_block(1);
    chk("R7 stop at 3 again", stop, 1);
    r = 1; cyc(); idle_in();
    chk("R7 stop falls", stop, 0);

    // random phase
    for (int n = 0; n < 30000; n++) begin
      int p;
      idle_in();
      p = $urandom_range(99);
      v = (n % 2000 < 1000) ? (p < 85) : (p < 40);
      d = 8'($urandom);
      if (m_state == 2'd1 && v && m_cnt == 63) s = ($urandom_range(99) < 85);
      else if (m_state == 2'd2) s = ($urandom_range(99) < 8);
      else s = ($urandom_range(99) < 2);
      r = ($urandom_range(999) < ((n % 3000 < 1500) ? 16 : 12));
      st = (m_state == 2'd0) ? ($urandom_range(99) < 5) : ($urandom_range(99) < 2);
      cyc();
    end
    idle_in();
    cyc();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule